// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits beside a CPU core and decides which interrupt the core should take next. Fourteen hardware request lines each feed a dedicated pending latch, occupying slot indices 2 to 15. A separate trap input from the CPU stands for the software interrupt at slot 1, and that input has no latch. A latched request at slot 2 is the watchdog. It and the trap are taken whether or not the master flag is set. Every slot from 3 to 15 is maskable and needs both the master flag and its own enable bit.

Among eligible requests the lowest slot index wins. The block presents that slot's vector address to the core. Vectors start at FFFEh for slot 0 and fall by two per slot, so slot 15 maps to FFE0h. When the core strobes accept, the block clears the winning latch and drops the master flag, so a nested interrupt is taken only if software sets the flag again.

A small register port lets software read and clear the latches, read and write the enables, and read and write the master flag. Software can never set a latch.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, all latches, all enable bits and the master flag are 0, and irq_valid is 0.
- R2: A 1 on req_i bit k (k in 2..15) sets latch k at the next clock edge. Bits 0 and 1 of req_i are ignored. Reading with reg_sel=0 returns the latches, with bit k holding slot k and bits 1:0 always 0.
- R3: A write with reg_sel=0 clears every latch whose reg_wdata bit is 0. A latch whose reg_wdata bit is 1 is left unchanged, so software can never set a latch.
- R4: A write with reg_sel=1 loads enable bits 15..3 from reg_wdata, and reading with reg_sel=1 returns them with bits 2:0 as 0. A write with reg_sel=2 loads the master flag from reg_wdata bit 0, and reading with reg_sel=2 returns the flag in bit 0. Reading with reg_sel=3 returns 0.
- R5: A pending slot k in 3..15 is eligible only when the master flag and enable bit k are both 1. A pending slot 2 is eligible regardless of the master flag.
- R6: While trap_i is 1, the block presents slot 1 (vector FFFCh) with irq_valid=1, above every latched slot and regardless of the master flag. Accepting it clears no latch.
- R7: irq_valid and irq_vector follow the current inputs and state in the same cycle. The vector belongs to the lowest eligible index and equals FFFEh minus twice that index.
- R8: ack_i while irq_valid=1 clears the winner's latch and the master flag at the next edge. The accept wins over a master-flag write made in the same cycle.
- R9: If a request for slot k arrives in the same cycle as a software clear or an accept of slot k, latch k stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 16 | Hardware request pulses, bit k for slot k (bits 1:0 unused) |
| trap_i | input | 1 | Software trap, held by the CPU until accepted |
| ack_i | input | 1 | CPU accepts the presented interrupt |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 latches, 1 enables, 2 master flag |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_sel |
| irq_valid | output | 1 | An eligible interrupt is being presented |
| irq_vector | output | 16 | Vector address of the presented interrupt |

## Verification
irq_valid, irq_vector and reg_rdata are combinational and are due in the same cycle as the inputs or state that drive them. The bench drives inputs on the falling edge and samples these outputs a short delay later, before the next rising edge. Latch, enable and master-flag updates, including clears on accept, become visible one rising edge after the stimulus. The bench reads them back through the register port at the following falling edge. Same-cycle collisions between set, clear, accept and flag write are produced by driving both stimuli in one low phase.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int NUM_SLOTS      = 16;
    localparam int IDX_W          = $clog2(NUM_SLOTS);
    localparam int TRAP_IDX       = 1;
    localparam int WDOG_IDX       = 2;
    localparam int FIRST_MASKABLE = 3;

    typedef logic [NUM_SLOTS-1:0] slot_vec_t;
    typedef logic [IDX_W-1:0]     slot_idx_t;

    typedef enum logic [1:0] {
        SEL_LATCH  = 2'd0,
        SEL_ENABLE = 2'd1,
        SEL_MASTER = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic      valid;
        logic      is_trap;
        slot_idx_t idx;
    } grant_t;

    function automatic slot_vec_t latch_mask();
        slot_vec_t m;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            m[i] = (i >= WDOG_IDX);
        end
        return m;
    endfunction

    function automatic slot_vec_t enable_mask();
        slot_vec_t m;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            m[i] = (i >= FIRST_MASKABLE);
        end
        return m;
    endfunction

    function automatic logic [15:0] vector_of(input logic [15:0] base,
                                              input logic [15:0] step,
                                              input slot_idx_t idx);
        return base - step * 16'(idx);
    endfunction

endpackage

// File: rtl/irqc_latch_bank.sv
module irqc_latch_bank
    import irqc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  slot_vec_t set_mask,
    input  slot_vec_t clr_mask,
    output slot_vec_t latch_q
);

    localparam slot_vec_t LMASK = latch_mask();

    // A set in the same cycle overrides any clear.
    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= '0;
        end else begin
            latch_q <= ((latch_q & ~clr_mask) | set_mask) & LMASK;
        end
    end

endmodule

// File: rtl/irqc_ctrl_regs.sv
module irqc_ctrl_regs
    import irqc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  reg_sel_e  wr_sel,
    input  slot_vec_t wr_data,
    input  logic      accept,
    output slot_vec_t en_q,
    output logic      imf_q
);

    localparam slot_vec_t EMASK = enable_mask();

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (wr_en && wr_sel == SEL_ENABLE) begin
            en_q <= wr_data & EMASK;
        end
    end

    // Accept drops the master flag, and it wins over a simultaneous write.
    always_ff @(posedge clk) begin
        if (rst) begin
            imf_q <= 1'b0;
        end else if (accept) begin
            imf_q <= 1'b0;
        end else if (wr_en && wr_sel == SEL_MASTER) begin
            imf_q <= wr_data[0];
        end
    end

endmodule

// File: rtl/irqc_prio_pick.sv
module irqc_prio_pick
    import irqc_pkg::*;
(
    input  slot_vec_t latch_q,
    input  slot_vec_t en_q,
    input  logic      imf_q,
    input  logic      trap,
    output grant_t    grant
);

    slot_vec_t eligible;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_elig
        if (g == WDOG_IDX) begin : g_nmi
            assign eligible[g] = latch_q[g];
        end else if (g >= FIRST_MASKABLE) begin : g_mask
            assign eligible[g] = latch_q[g] & en_q[g] & imf_q;
        end else begin : g_none
            assign eligible[g] = 1'b0;
        end
    end

    // Scan from lowest priority upward so the lowest index lands last.
    always_comb begin
        grant = '0;
        for (int i = NUM_SLOTS - 1; i >= WDOG_IDX; i--) begin
            if (eligible[i]) begin
                grant.valid   = 1'b1;
                grant.is_trap = 1'b0;
                grant.idx     = slot_idx_t'(i);
            end
        end
        if (trap) begin
            grant.valid   = 1'b1;
            grant.is_trap = 1'b1;
            grant.idx     = slot_idx_t'(TRAP_IDX);
        end
    end

endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
    import irqc_pkg::*;
#(
    parameter logic [15:0] VEC_BASE = 16'hFFFE,
    parameter logic [15:0] VEC_STEP = 16'd2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] req_i,
    input  logic        trap_i,
    input  logic        ack_i,
    input  logic        reg_we,
    input  logic [1:0]  reg_sel,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        irq_valid,
    output logic [15:0] irq_vector
);

    localparam slot_vec_t LMASK = latch_mask();

    reg_sel_e  sel;
    slot_vec_t latch_q;
    slot_vec_t en_q;
    logic      imf_q;
    grant_t    grant;
    slot_idx_t win_idx;
    logic      accept;
    slot_vec_t sw_clr;
    slot_vec_t acc_clr;
    slot_vec_t set_mask;

    assign sel      = reg_sel_e'(reg_sel);
    assign win_idx  = grant.idx;
    assign accept   = ack_i & grant.valid;
    assign set_mask = req_i & LMASK;
    assign sw_clr   = (reg_we && sel == SEL_LATCH) ? ~reg_wdata : '0;
    assign acc_clr  = (accept && !grant.is_trap) ? (slot_vec_t'(1) << win_idx) : '0;

    irqc_latch_bank u_latch (
        .clk      (clk),
        .rst      (rst),
        .set_mask (set_mask),
        .clr_mask (sw_clr | acc_clr),
        .latch_q  (latch_q)
    );

    irqc_ctrl_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_we),
        .wr_sel  (sel),
        .wr_data (reg_wdata),
        .accept  (accept),
        .en_q    (en_q),
        .imf_q   (imf_q)
    );

    irqc_prio_pick u_pick (
        .latch_q (latch_q),
        .en_q    (en_q),
        .imf_q   (imf_q),
        .trap    (trap_i),
        .grant   (grant)
    );

    assign irq_valid  = grant.valid;
    assign irq_vector = grant.valid ? vector_of(VEC_BASE, VEC_STEP, win_idx) : '0;

    always_comb begin
        unique case (sel)
            SEL_LATCH:  reg_rdata = latch_q;
            SEL_ENABLE: reg_rdata = en_q;
            SEL_MASTER: reg_rdata = {15'd0, imf_q};
            default:    reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/vec_irq_ctrl_chk.sv
module vec_irq_ctrl_chk #(
    parameter logic [15:0] VEC_BASE = 16'hFFFE,
    parameter logic [15:0] VEC_STEP = 16'd2
) (
    input logic        clk,
    input logic        rst,
    input logic [15:0] req_i,
    input logic        trap_i,
    input logic        ack_i,
    input logic        irq_valid,
    input logic [15:0] irq_vector,
    input logic [15:0] latch_q,
    input logic        imf_q,
    input logic [3:0]  win_idx
);

    // R2
    latch_set_chk: assert property (@(posedge clk) disable iff (rst)
        (|(req_i & 16'hFFFC)) |=>
        ((latch_q & $past(req_i & 16'hFFFC)) == $past(req_i & 16'hFFFC)));

    // R5
    masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!imf_q && !trap_i && !latch_q[2]) |-> !irq_valid);

    // R6
    trap_top_chk: assert property (@(posedge clk) disable iff (rst)
        trap_i |-> (irq_valid && irq_vector == VEC_BASE - VEC_STEP));

    // R7
    vec_range_chk: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> (irq_vector <= VEC_BASE - VEC_STEP &&
                       irq_vector >= VEC_BASE - 16'd15 * VEC_STEP));

    // R8
    accept_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_i && irq_valid && !trap_i && !req_i[win_idx]) |=>
        !latch_q[$past(win_idx)]);

    // R8
    imf_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_i && irq_valid) |=> !imf_q);

endmodule

bind vec_irq_ctrl vec_irq_ctrl_chk #(
    .VEC_BASE (VEC_BASE),
    .VEC_STEP (VEC_STEP)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_i      (req_i),
    .trap_i     (trap_i),
    .ack_i      (ack_i),
    .irq_valid  (irq_valid),
    .irq_vector (irq_vector),
    .latch_q    (latch_q),
    .imf_q      (imf_q),
    .win_idx    (win_idx)
);

// File: tb/vec_irq_ctrl_bench.sv
`timescale 1ns/1ps
module vec_irq_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] req_i = '0;
    logic        trap_i = 1'b0;
    logic        ack_i = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd3;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq_valid;
    logic [15:0] irq_vector;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    vec_irq_ctrl u_vec_irq_ctrl (
        .clk(clk), .rst(rst), .req_i(req_i), .trap_i(trap_i), .ack_i(ack_i),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_valid(irq_valid), .irq_vector(irq_vector)
    );

    function automatic logic [15:0] vec_exp(input int idx);
        return 16'hFFFE - 16'(2 * idx);
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] data);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
        tick();
        reg_we = 1'b0; reg_sel = 2'd3;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [15:0] data);
        reg_sel = sel;
        #0.5;
        data = reg_rdata;
        reg_sel = 2'd3;
    endtask

    task automatic pulse(input logic [15:0] m);
        req_i = m;
        tick();
        req_i = '0;
    endtask

    task automatic accept();
        ack_i = 1'b1;
        tick();
        ack_i = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] v;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(2'd0, v); check("R1 latches", v, 16'h0);
        rd(2'd1, v); check("R1 enables", v, 16'h0);
        rd(2'd2, v); check("R1 master", v, 16'h0);
        #0.5; check("R1 valid", 16'(irq_valid), 16'h0);

        // R2 bits 1:0 of req_i ignored
        pulse(16'h0003);
        rd(2'd0, v); check("R2 low bits ignored", v, 16'h0);

        // R4 register readback and masking
        wr(2'd1, 16'hFFFF);
        rd(2'd1, v); check("R4 enable mask", v, 16'hFFF8);
        wr(2'd2, 16'hFFFF);
        rd(2'd2, v); check("R4 master", v, 16'h0001);
        rd(2'd3, v); check("R4 unused sel", v, 16'h0);
        wr(2'd2, 16'h0);

        // R2 R5 R7 R3: single-slot sweep over master and enable combinations
        for (int k = 2; k < 16; k++) begin
            for (int c = 0; c < 4; c++) begin
                logic im, en, ev;
                im = c[0]; en = c[1];
                wr(2'd1, en ? (16'h1 << k) : 16'h0);
                wr(2'd2, {15'd0, im});
                pulse(16'h1 << k);
                rd(2'd0, v); check("R2 latch set", v, 16'h1 << k);
                ev = (k == 2) || (im && en);
                #0.5;
                check("R5 eligibility", 16'(irq_valid), 16'(ev));
                if (ev) check("R7 vector", irq_vector, vec_exp(k));
                wr(2'd0, ~(16'h1 << k));
                rd(2'd0, v); check("R3 sw clear", v, 16'h0);
                #0.5; check("R3 valid after clear", 16'(irq_valid), 16'h0);
            end
        end

        // R7 R8: pairwise priority and accept
        wr(2'd1, 16'hFFFF);
        for (int a = 2; a < 16; a++) begin
            for (int b = a + 1; b < 16; b++) begin
                wr(2'd2, 16'h1);
                pulse((16'h1 << a) | (16'h1 << b));
                #0.5; check("R7 pair winner", irq_vector, vec_exp(a));
                accept();
                rd(2'd0, v); check("R8 winner cleared", v, 16'h1 << b);
                rd(2'd2, v); check("R8 master dropped", v, 16'h0);
                wr(2'd2, 16'h1);
                #0.5; check("R7 next vector", irq_vector, vec_exp(b));
                accept();
                rd(2'd0, v); check("R8 second cleared", v, 16'h0);
            end
        end

        // R6 trap above latches, no latch cleared
        wr(2'd2, 16'h1);
        pulse(16'h1 << 4);
        trap_i = 1'b1;
        #0.5; check("R6 trap vector", irq_vector, 16'hFFFC);
        ack_i = 1'b1;
        tick();
        ack_i = 1'b0; trap_i = 1'b0;
        rd(2'd0, v); check("R6 latch kept", v, 16'h1 << 4);
        rd(2'd2, v); check("R8 master dropped by trap", v, 16'h0);
        #0.5; check("R5 masked after accept", 16'(irq_valid), 16'h0);
        trap_i = 1'b1;
        #0.5; check("R6 trap ignores master", irq_vector, 16'hFFFC);
        trap_i = 1'b0;
        pulse(16'h1 << 2);
        #0.5; check("R5 watchdog ignores master", irq_vector, vec_exp(2));
        wr(2'd0, 16'h0);

        // R3 writing 1 leaves latch unchanged
        pulse(16'h1 << 5);
        wr(2'd0, 16'hFFFF);
        rd(2'd0, v); check("R3 write one no effect", v, 16'h1 << 5);
        wr(2'd0, 16'h0);

        // R9 set beats software clear
        req_i = 16'h1 << 5; reg_we = 1'b1; reg_sel = 2'd0; reg_wdata = 16'h0;
        tick();
        req_i = '0; reg_we = 1'b0; reg_sel = 2'd3;
        rd(2'd0, v); check("R9 set over clear", v, 16'h1 << 5);

        // R9 set beats accept
        wr(2'd2, 16'h1);
        #0.5; check("R7 vector slot5", irq_vector, vec_exp(5));
        req_i = 16'h1 << 5; ack_i = 1'b1;
        tick();
        req_i = '0; ack_i = 1'b0;
        rd(2'd0, v); check("R9 set over accept", v, 16'h1 << 5);

        // R8 accept beats master write
        wr(2'd2, 16'h1);
        ack_i = 1'b1; reg_we = 1'b1; reg_sel = 2'd2; reg_wdata = 16'h1;
        tick();
        ack_i = 1'b0; reg_we = 1'b0; reg_sel = 2'd3;
        rd(2'd2, v); check("R8 accept over write", v, 16'h0);
        rd(2'd0, v); check("R8 latch cleared", v, 16'h0);

        finish_run();
    end

endmodule